// File: doc/BRIEF.md
# Sequential Booth Radix-2 Signed Multiplier

This block forms the signed product of two 8-bit two's-complement operands, retiring one multiplier bit per clock. Each pulse on `start_i`, when the unit is idle, captures both operands, clears the accumulator and clears the saved "bit below" flag. The unit then runs a fixed number of iterations. In each one it pairs the lowest multiplier bit with the bit that was shifted out in the previous iteration. That pair chooses whether the accumulator keeps its value, adds the multiplicand, or subtracts it. The accumulator and the multiplier then shift right together as one arithmetic word, so the sign is kept.

When the last iteration has finished, `done_o` pulses high for one cycle and the 16-bit product appears on `product_o`. The product holds its value until the next accepted start. While the unit is busy, the start input is ignored. Typical use: pulse `start_i` with the operands, then wait for `done_o`.

Top module: `booth_seq_mul`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy_o` and `done_o` are 0 and `product_o` is 0.
- R2: `start_i` high on a clock edge while `busy_o` is 0 captures `op_a_i` as multiplicand and `op_b_i` as multiplier, and `busy_o` reads 1 after that edge.
- R3: A (current multiplier bit, previous bit) pair of 00 or 11 leaves the accumulator unchanged before the shift.
- R4: A pair of 01 adds the multiplicand to the accumulator.
- R5: A pair of 10 subtracts the multiplicand from the accumulator.
- R6: The previous-bit flag is cleared by every accepted start, so the first iteration treats the bit below the multiplier LSB as 0.
- R7: Exactly 8 iterations follow an accepted start. `done_o` is high for exactly one cycle, on the edge where `busy_o` falls, 9 edges after the start edge counting that edge as the first.
- R8: `product_o` changes only on the edge that raises `done_o`, and holds otherwise, including when the operand inputs change.
- R9: A start pulse while `busy_o` is 1 has no effect. The running product and the completion timing are those of the first start.
- R10: `product_o` equals the signed 16-bit product of the two operands for every operand pair, including -128 × -128 = +16384 and -128 × 127 = -16256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, sampled on each edge |
| op_a_i | input | 8 | Multiplicand, two's complement |
| op_b_i | input | 8 | Multiplier, two's complement |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 16 | Signed product, held until the next start |

## Verification
The hardest case to reach from the ports is a subtraction with the multiplicand at -128. Negating -128 does not fit in 8 bits, so this step overflows unless the accumulator has a guard bit. The bench reaches it by placing -128 as the multiplicand against multipliers whose low bit is 1 (so the first pair is 10), and also by -128 × -128. It runs a sweep of strided operand pairs and compares each result with a signed reference. A second start injected in the middle of a run shows that a start while busy changes neither the result nor the timing.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        OP_PASS = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_e;

    // Pairing of the current multiplier LSB with the bit shifted out last step.
    function automatic booth_op_e booth_decode(input logic cur, input logic prev);
        booth_op_e op;
        case ({cur, prev})
            2'b01:   op = OP_ADD;
            2'b10:   op = OP_SUB;
            default: op = OP_PASS;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic      cur_i,
    input  logic      prev_i,
    output booth_op_e op_o
);
    always_comb op_o = booth_decode(cur_i, prev_i);
endmodule

// File: rtl/booth_alu.sv
module booth_alu
    import booth_pkg::*;
#(
    parameter int AW           = 9,
    parameter bit SHARED_ADDER = 1'b1
) (
    input  logic [AW-1:0] acc_i,
    input  logic [AW-1:0] mcand_i,
    input  booth_op_e     op_i,
    output logic [AW-1:0] res_o
);
    generate
        if (SHARED_ADDER) begin : g_shared
            // One adder: subtract is add of inverted operand with carry-in.
            logic [AW-1:0] operand;
            logic          cin;
            always_comb begin
                operand = '0;
                cin     = 1'b0;
                if (op_i == OP_ADD) begin
                    operand = mcand_i;
                end else if (op_i == OP_SUB) begin
                    operand = ~mcand_i;
                    cin     = 1'b1;
                end
                res_o = acc_i + operand + AW'(cin);
            end
        end else begin : g_split
            always_comb begin
                case (op_i)
                    OP_ADD:  res_o = acc_i + mcand_i;
                    OP_SUB:  res_o = acc_i - mcand_i;
                    default: res_o = acc_i;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
    parameter int STEPS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic last_o,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(STEPS + 1);

    logic          busy_q;
    logic          done_q;
    logic [CW-1:0] cnt_q;

    assign load_o = start_i && !busy_q;
    assign step_o = busy_q;
    assign last_o = busy_q && (cnt_q == CW'(STEPS - 1));
    assign busy_o = busy_q;
    assign done_o = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= last_o;
            if (load_o) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end else if (step_o) begin
                cnt_q <= cnt_q + 1'b1;
                if (last_o) busy_q <= 1'b0;
            end
        end
    end

    // Independent run-length counter used only by the checks below.
    logic [CW-1:0] chk_run_q;
    always_ff @(posedge clk) begin
        if (rst)           chk_run_q <= '0;
        else if (load_o)   chk_run_q <= '0;
        else if (busy_q)   chk_run_q <= chk_run_q + 1'b1;
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);                               // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);                                             // R7
    AST_DONE_FALL: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($fell(busy_o) && chk_run_q == CW'(STEPS)));          // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !last_o) |=> busy_o);                      // R9
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
    import booth_pkg::*;
#(
    parameter int W            = 8,
    parameter bit SHARED_ADDER = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic [W-1:0]   op_a_i,
    input  logic [W-1:0]   op_b_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*W-1:0] product_o
);
    localparam int AW = W + 1;   // guard bit for subtracting the most negative multiplicand
    localparam int PW = 2 * W;

    logic load, step, last;

    booth_ctrl #(.STEPS(W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .last_o  (last),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    logic [W-1:0]  mcand_q;
    logic [W-1:0]  mplr_q;
    logic [AW-1:0] acc_q;
    logic          prev_q;
    logic [PW-1:0] prod_q;

    booth_op_e     op;
    logic [AW-1:0] mcand_ext;
    logic [AW-1:0] alu_res;
    logic [AW-1:0] acc_nxt;
    logic [W-1:0]  mplr_nxt;

    booth_recode u_recode (
        .cur_i  (mplr_q[0]),
        .prev_i (prev_q),
        .op_o   (op)
    );

    assign mcand_ext = {mcand_q[W-1], mcand_q};

    booth_alu #(.AW(AW), .SHARED_ADDER(SHARED_ADDER)) u_alu (
        .acc_i   (acc_q),
        .mcand_i (mcand_ext),
        .op_i    (op),
        .res_o   (alu_res)
    );

    // Arithmetic right shift of the joined {accumulator, multiplier} word.
    assign acc_nxt  = {alu_res[AW-1], alu_res[AW-1:1]};
    assign mplr_nxt = {alu_res[0], mplr_q[W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            mplr_q  <= '0;
            acc_q   <= '0;
            prev_q  <= 1'b0;
            prod_q  <= '0;
        end else if (load) begin
            mcand_q <= op_a_i;
            mplr_q  <= op_b_i;
            acc_q   <= '0;
            prev_q  <= 1'b0;
        end else if (step) begin
            acc_q  <= acc_nxt;
            mplr_q <= mplr_nxt;
            prev_q <= mplr_q[0];
            if (last) prod_q <= {acc_nxt[W-1:0], mplr_nxt};
        end
    end

    assign product_o = prod_q;

    AST_OPERANDS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        load |=> (mcand_q == $past(op_a_i) && mplr_q == $past(op_b_i)));  // R2
    AST_PREV_CLEARED: assert property (@(posedge clk) disable iff (rst)
        load |=> (prev_q == 1'b0 && acc_q == '0));                         // R6
    AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(product_o));                                   // R8
    AST_BUSY_OPERANDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(mcand_q));                         // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (acc_q[AW-1] == acc_q[W-1]));                           // R10
endmodule

// File: tb/booth_seq_mul_bench.sv
module booth_seq_mul_bench;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start_i = 1'b0;
    logic [W-1:0]   op_a_i = '0;
    logic [W-1:0]   op_b_i = '0;
    logic           busy_o, done_o;
    logic [2*W-1:0] product_o;

    booth_seq_mul #(.W(W)) u_booth_seq_mul (
        .clk(clk), .rst(rst), .start_i(start_i), .op_a_i(op_a_i),
        .op_b_i(op_b_i), .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [7:0]  a;
        logic [7:0]  b;
        logic [15:0] p;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{8'd25,    -8'sd19,  -16'sd475},
        '{8'd0,     8'd0,     16'd0},
        '{8'd7,     8'd0,     16'd0},
        '{8'd0,     -8'sd128, 16'd0},
        '{-8'sd1,   -8'sd1,   16'd1},
        '{8'd127,   8'd127,   16'd16129},
        '{-8'sd128, 8'd127,   -16'sd16256},
        '{8'd127,   -8'sd128, -16'sd16256},
        '{-8'sd128, -8'sd128, 16'd16384},
        '{-8'sd128, 8'd1,     -16'sd128},
        '{8'd1,     -8'sd128, -16'sd128},
        '{-8'sd5,   8'd3,     -16'sd15},
        '{8'd85,    -8'sd86,  -16'sd7310},
        '{-8'sd1,   8'd127,   -16'sd127},
        '{-8'sd128, -8'sd1,   16'd128}
    };

    // Pulse start at a negedge, then count negedges until done is seen.
    task automatic run_mul(input logic [7:0] a, input logic [7:0] b,
                           output logic [15:0] p, output int waits);
        @(negedge clk);
        op_a_i  = a;
        op_b_i  = b;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        waits = 0;
        while (!done_o && waits < 40) begin
            @(negedge clk);
            waits++;
        end
        p = product_o;
    endtask

    initial begin
        logic [15:0] p;
        int          waits;
        logic [15:0] held;

        repeat (3) @(negedge clk);
        check(busy_o == 1'b0 && done_o == 1'b0 && product_o == 16'd0, "R1 reset outputs",
              {busy_o, done_o, product_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy_o == 1'b0 && done_o == 1'b0 && product_o == 16'd0, "R1 after reset",
              {busy_o, done_o, product_o}, 0);

        // R2: busy after accepted start
        op_a_i = 8'd3; op_b_i = 8'd2; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
        waits = 0;
        while (!done_o && waits < 40) begin @(negedge clk); waits++; end
        check(waits == 8, "R7 done after eight iterations", waits, 8);
        check(busy_o == 1'b0, "R7 busy falls with done", busy_o, 0);
        check(product_o == 16'd6, "R4 R5 3*2", product_o, 6);
        @(negedge clk);
        check(done_o == 1'b0, "R7 done single cycle", done_o, 0);

        // Vector table: R3 (00/11 runs), R4, R5, R6, R10
        for (int i = 0; i < NV; i++) begin
            run_mul(VECS[i].a, VECS[i].b, p, waits);
            check(p == VECS[i].p, $sformatf("R10 vector %0d", i),
                  $signed(p), $signed(VECS[i].p));
            check(waits == 8, "R7 latency", waits, 8);
        end

        // R3: multiplier all zeros (pairs 00) and all ones (pairs 11 after one 10)
        run_mul(8'd77, 8'd0, p, waits);
        check(p == 16'd0, "R3 pass on 00 pairs", $signed(p), 0);
        run_mul(8'd77, 8'hFF, p, waits);
        check($signed(p) == -77, "R3 R5 pass on 11 pairs", $signed(p), -77);
        // R4/R5: alternating bits give add/subtract every step
        run_mul(8'd9, 8'h55, p, waits);
        check($signed(p) == 765, "R4 R5 alternating 0x55", $signed(p), 765);
        run_mul(8'd9, 8'hAA, p, waits);
        check($signed(p) == -774, "R4 R5 alternating 0xAA", $signed(p), -774);

        // R6: a run ending with prev=1 must not leak into the next run
        run_mul(8'd1, 8'h80, p, waits);
        run_mul(8'd10, 8'd2, p, waits);
        check($signed(p) == 20, "R6 previous bit cleared", $signed(p), 20);

        // R8: product holds while operands change without start
        held = product_o;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            op_a_i = 8'(k * 37);
            op_b_i = 8'(k * 91 + 3);
            check(product_o == held && done_o == 1'b0, "R8 product held", product_o, held);
        end

        // R9: start while busy is ignored
        @(negedge clk);
        op_a_i = 8'd11; op_b_i = -8'sd6; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        op_a_i = 8'd100; op_b_i = 8'd100; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        waits = 4;
        while (!done_o && waits < 40) begin @(negedge clk); waits++; end
        check(waits == 8, "R9 timing unchanged", waits, 8);
        check($signed(product_o) == -66, "R9 result of first start", $signed(product_o), -66);
        @(negedge clk);
        check(busy_o == 1'b0, "R9 no second run", busy_o, 0);

        // R10: strided sweep against a signed reference
        for (int ia = -128; ia < 128; ia += 19) begin
            for (int ib = -128; ib < 128; ib += 23) begin
                int exp_p;
                exp_p = ia * ib;
                run_mul(8'(ia), 8'(ib), p, waits);
                check($signed(p) == exp_p, $sformatf("R10 sweep %0d*%0d", ia, ib),
                      $signed(p), exp_p);
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule